// File: doc/BRIEF.md
# Event Interrupt and Wake-Up Steering Controller

This block sits beside the timekeeping core of a real-time-clock peripheral. It merges three event sources into one shared interrupt request flag and drives two further outputs: an active-low interrupt line and an active-low power wake-up line. The three sources are a time/date alarm, a kickstart (push-button) event and a watchdog expiry. Each source arrives as a one-cycle pulse and sets its own sticky flag. Whether that flag also raises the shared interrupt request is decided by an enable bit for that source in an 8-bit control register. The alarm flag can also pull the wake-up line through a separate enable. The watchdog expiry is routed by a steering bit, either onto the interrupt path or into a fixed-width active-low reset pulse.

Software uses a small synchronous register bus with two registers. The first is the control register. The second is a status register that returns the four flags and clears them when it is read. Read data is registered and is valid in the cycle after the read strobe. Oscillator control, calendar counting and alarm comparison live elsewhere. This block only receives their event pulses.

Top module: `rtc_event_steer`

## Requirements
- R1: After synchronous reset the control register reads 0x00, the status register reads 0x00, and `irq_n`, `pwr_n` and `wdog_rst_n` are all 1.
- R2: The control register at address 0 holds bit 7 transfer enable, bit 6 crystal select, bit 5 burst enable, bit 4 wake enable, bit 3 alarm interrupt enable, bit 2 kick interrupt enable, bit 1 watchdog enable and bit 0 watchdog steering. A write stores all eight bits, and a read returns them. No internal event alters any bit except watchdog enable (see R6).
- R3: An `alarm_evt` pulse always sets the alarm flag (status bit 6). It also sets the interrupt request flag (status bit 7) only when control bit 3 is 1.
- R4: A `kick_evt` pulse always sets the kick flag (status bit 5). It also sets the interrupt request flag only when control bit 2 is 1.
- R5: A `wdog_evt` pulse is ignored while control bit 1 is 0. While control bit 1 is 1, the pulse sets the watchdog flag (status bit 4). If control bit 0 is also 0, it sets the interrupt request flag as well.
- R6: A `wdog_evt` pulse that arrives while control bits 1 and 0 are both 1 drives `wdog_rst_n` low for exactly PULSE_LEN cycles, starting the cycle after the event. The same event clears control bit 1 and does not set the interrupt request flag.
- R7: `irq_n` is 0 exactly while the interrupt request flag is 1. It falls in the cycle after the causing event.
- R8: `pwr_n` is 0 exactly while the alarm flag and control bit 4 are both 1. Writing bit 4 to 0 releases it in the cycle after the write.
- R9: A read of the status register at address 1 returns {request, alarm, kick, watchdog, 0000} in the following cycle, and all four flags read 0 from that cycle on.
- R10: An event pulse that coincides with a status read leaves its flag set (and the request flag, if enabled), while the read returns the pre-event value.
- R11: Setting an interrupt enable while the flag for that source is already set does not raise the request flag. Only a new event does.
- R12: Writes to the status address, and to unmapped addresses, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data, held between reads |
| alarm_evt | input | 1 | Time/date alarm match pulse |
| kick_evt | input | 1 | Kickstart pulse |
| wdog_evt | input | 1 | Watchdog expiry pulse |
| irq_n | output | 1 | Active-low interrupt request |
| pwr_n | output | 1 | Active-low power wake-up request |
| wdog_rst_n | output | 1 | Active-low watchdog reset pulse |

## Verification
The hardest case to reach is an event pulse that lands in the same cycle as a clearing status read, because the flag then has to survive the clear. The stimulus places an alarm pulse and a status read on one edge, then reads again to confirm that the flag survived. A second hard case is the watchdog reset path, which needs both the enable bit and the steering bit set before the event, and which then clears the enable bit. The bench therefore reads the control register back after the pulse. Randomised traffic then mixes writes, reads and events against a behavioural model that is compared on every clock.

// File: rtl/rtc_steer_pkg.sv
package rtc_steer_pkg;
  localparam int unsigned REG_W = 8;

  // control register bit positions
  localparam int B_XFER  = 7;
  localparam int B_XTAL  = 6;
  localparam int B_BURST = 5;
  localparam int B_WAKE  = 4;
  localparam int B_AIE   = 3;
  localparam int B_KIE   = 2;
  localparam int B_WDE   = 1;
  localparam int B_WDS   = 0;

  // sticky flag cause indices
  localparam int N_SRC   = 3;
  localparam int S_ALARM = 2;
  localparam int S_KICK  = 1;
  localparam int S_WDOG  = 0;

  typedef struct packed {
    logic irq;
    logic alarm;
    logic kick;
    logic wdog;
  } flags_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_steer_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         hw_wde_clr,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] ctrl_nxt
);
  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_en) ctrl_nxt = wdata;
    if (hw_wde_clr) ctrl_nxt[B_WDE] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nxt;
  end

  AST_XFER_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(ctrl_q[B_XFER])); // R2
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags
  import rtc_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   alarm_evt,
  input  logic   kick_evt,
  input  logic   wdog_evt,
  input  logic   alarm_ie,
  input  logic   kick_ie,
  input  logic   wdog_steer,
  input  logic   clr,
  output flags_t flags_q,
  output flags_t flags_nxt
);
  logic [N_SRC-1:0] src_set, src_q, src_nxt, src_irq;
  logic irq_set, irq_q, irq_nxt;

  assign src_set[S_ALARM] = alarm_evt;
  assign src_set[S_KICK]  = kick_evt;
  assign src_set[S_WDOG]  = wdog_evt;

  assign src_irq[S_ALARM] = alarm_evt & alarm_ie;
  assign src_irq[S_KICK]  = kick_evt & kick_ie;
  assign src_irq[S_WDOG]  = wdog_evt & ~wdog_steer;

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      // set beats clear
      assign src_nxt[gi] = src_set[gi] | (src_q[gi] & ~clr);
      always_ff @(posedge clk) begin
        if (rst) src_q[gi] <= 1'b0;
        else     src_q[gi] <= src_nxt[gi];
      end
    end
  endgenerate

  assign irq_set = |src_irq;
  assign irq_nxt = irq_set | (irq_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_nxt;
  end

  assign flags_q   = '{irq: irq_q, alarm: src_q[S_ALARM], kick: src_q[S_KICK], wdog: src_q[S_WDOG]};
  assign flags_nxt = '{irq: irq_nxt, alarm: src_nxt[S_ALARM], kick: src_nxt[S_KICK], wdog: src_nxt[S_WDOG]};

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(alarm_evt) && !$past(rst)) |-> flags_q.alarm); // R10
  AST_CLR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !$past(kick_evt)) |-> !flags_q.kick); // R9
  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q.alarm) |-> $past(alarm_evt)); // R3
endmodule

// File: rtl/rtc_wdog_pulse.sv
module rtc_wdog_pulse #(
  parameter int unsigned PULSE_LEN = 4,
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_n
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (trig)              cnt_nxt = CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)  cnt_nxt = cnt_q - CNT_W'(1);
    else                   cnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_n <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      pulse_n <= (cnt_nxt == '0);
    end
  end

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_n) |-> $past(trig)); // R6
endmodule

// File: rtl/rtc_event_steer.sv
module rtc_event_steer
  import rtc_steer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned PULSE_LEN = 4,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              alarm_evt,
  input  logic              kick_evt,
  input  logic              wdog_evt,
  output logic              irq_n,
  output logic              pwr_n,
  output logic              wdog_rst_n
);
  localparam int unsigned FLAG_N = $bits(flags_t);

  logic sel_ctrl, sel_stat, ctrl_wr, stat_rd;
  logic wdog_q, wdog_to_rst;
  logic [REG_W-1:0] ctrl_q, ctrl_nxt, stat_word;
  flags_t flags_q, flags_nxt;

  assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
  assign sel_stat = (bus_addr == ADDR_W'(STAT_ADDR));
  assign ctrl_wr  = bus_wr & sel_ctrl;
  assign stat_rd  = bus_rd & sel_stat;

  assign wdog_q      = wdog_evt & ctrl_q[B_WDE];
  assign wdog_to_rst = wdog_q & ctrl_q[B_WDS];

  rtc_ctrl_reg #(.W(REG_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (ctrl_wr),
    .wdata      (bus_wdata),
    .hw_wde_clr (wdog_to_rst),
    .ctrl_q     (ctrl_q),
    .ctrl_nxt   (ctrl_nxt)
  );

  rtc_evt_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .alarm_evt  (alarm_evt),
    .kick_evt   (kick_evt),
    .wdog_evt   (wdog_q),
    .alarm_ie   (ctrl_q[B_AIE]),
    .kick_ie    (ctrl_q[B_KIE]),
    .wdog_steer (ctrl_q[B_WDS]),
    .clr        (stat_rd),
    .flags_q    (flags_q),
    .flags_nxt  (flags_nxt)
  );

  rtc_wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .trig    (wdog_to_rst),
    .pulse_n (wdog_rst_n)
  );

  assign stat_word = {flags_q, {(REG_W - FLAG_N){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_n     <= 1'b1;
      pwr_n     <= 1'b1;
    end else begin
      if (bus_rd) begin
        if (sel_ctrl)      bus_rdata <= ctrl_q;
        else if (sel_stat) bus_rdata <= stat_word;
        else               bus_rdata <= '0;
      end
      irq_n <= ~flags_nxt.irq;
      pwr_n <= ~(flags_nxt.alarm & ctrl_nxt[B_WAKE]);
    end
  end

  AST_IRQ_TRACKS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_n == !flags_q.irq); // R7
  AST_RST_CLEARS_WDE: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_rst_n) |-> !ctrl_q[B_WDE]); // R6
  AST_PWR_NEEDS_ALARM: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |-> flags_q.alarm); // R8
endmodule

// File: tb/rtc_event_steer_tb.sv
module rtc_event_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 4;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic alarm_evt = 0, kick_evt = 0, wdog_evt = 0;
  logic irq_n, pwr_n, wdog_rst_n;

  int vectors = 0, misses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_event_steer #(.ADDR_W(2), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_evt(alarm_evt), .kick_evt(kick_evt), .wdog_evt(wdog_evt),
    .irq_n(irq_n), .pwr_n(pwr_n), .wdog_rst_n(wdog_rst_n)
  );

  // behavioural reference model
  int m_ctrl, m_tdf, m_ksf, m_wdf, m_irqf, m_rdata, m_cnt;
  int m_irq_n, m_pwr_n, m_wrst_n;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_tdf = 0; m_ksf = 0; m_wdf = 0; m_irqf = 0;
      m_rdata = 0; m_cnt = 0; m_irq_n = 1; m_pwr_n = 1; m_wrst_n = 1;
    end else begin
      int c, wset, iset, clr;
      c = m_ctrl;
      clr = (bus_rd && bus_addr == 1);
      if (bus_rd) begin
        if (bus_addr == 0)      m_rdata = c;
        else if (bus_addr == 1) m_rdata = m_irqf*128 + m_tdf*64 + m_ksf*32 + m_wdf*16;
        else                    m_rdata = 0;
      end
      wset = wdog_evt && c[1];
      iset = (alarm_evt && c[3]) || (kick_evt && c[2]) || (wset && !c[0]);
      m_tdf  = alarm_evt ? 1 : (clr ? 0 : m_tdf);
      m_ksf  = kick_evt  ? 1 : (clr ? 0 : m_ksf);
      m_wdf  = wset      ? 1 : (clr ? 0 : m_wdf);
      m_irqf = iset      ? 1 : (clr ? 0 : m_irqf);
      if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata;
      if (wset && c[0]) m_ctrl = m_ctrl & 8'hFD;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (wset && c[0]) m_cnt = PLEN;
      m_wrst_n = (m_cnt == 0);
      m_irq_n = !m_irqf;
      m_pwr_n = !(m_tdf && m_ctrl[4]);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 rdata model", int'(bus_rdata), m_rdata);
      check("R7 irq_n model", int'(irq_n), m_irq_n);
      check("R8 pwr_n model", int'(pwr_n), m_pwr_n);
      check("R6 wdog_rst_n model", int'(wdog_rst_n), m_wrst_n);
    end
  end

  task automatic wr(input int a, input int d);
    bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    bus_rd = 1; bus_addr = 2'(a);
    @(negedge clk);
    bus_rd = 0;
    check(tag, int'(bus_rdata), exp);
  endtask

  task automatic evt(input int which);
    if (which == 0) alarm_evt = 1;
    if (which == 1) kick_evt = 1;
    if (which == 2) wdog_evt = 1;
    @(negedge clk);
    alarm_evt = 0; kick_evt = 0; wdog_evt = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", int'(irq_n), 1);
    check("R1 pwr_n", int'(pwr_n), 1);
    check("R1 wdog_rst_n", int'(wdog_rst_n), 1);
    rd_chk(0, 8'h00, "R1 ctrl");
    rd_chk(1, 8'h00, "R1 status");
    // R2 layout round trip
    wr(0, 8'hA5); rd_chk(0, 8'hA5, "R2 ctrl readback");
    wr(0, 8'h00);
    // R3 alarm without / with enable
    evt(0); check("R3 irq_n no enable", int'(irq_n), 1);
    rd_chk(1, 8'h40, "R3 alarm flag only");
    rd_chk(1, 8'h00, "R9 flags cleared");
    wr(0, 8'h08); evt(0);
    check("R7 irq_n low after alarm", int'(irq_n), 0);
    rd_chk(1, 8'hC0, "R3 alarm with request");
    check("R7 irq_n released after read", int'(irq_n), 1);
    // R4 kick
    wr(0, 8'h00); evt(1); rd_chk(1, 8'h20, "R4 kick without enable");
    wr(0, 8'h04); evt(1); rd_chk(1, 8'hA0, "R4 kick with enable");
    // R5 watchdog
    wr(0, 8'h00); evt(2); rd_chk(1, 8'h00, "R5 watchdog ignored when disabled");
    wr(0, 8'h02); evt(2); rd_chk(1, 8'h90, "R5 watchdog to request");
    // R6 watchdog reset pulse
    wr(0, 8'h03); evt(2);
    for (int i = 0; i < PLEN; i++) begin
      check("R6 pulse low", int'(wdog_rst_n), 0);
      @(negedge clk);
    end
    check("R6 pulse ended", int'(wdog_rst_n), 1);
    rd_chk(0, 8'h01, "R6 enable cleared");
    rd_chk(1, 8'h10, "R6 no request");
    // R8 wake-up
    wr(0, 8'h10); evt(0); check("R8 pwr low", int'(pwr_n), 0);
    wr(0, 8'h00); check("R8 pwr released by write", int'(pwr_n), 1);
    wr(0, 8'h10); check("R8 pwr again", int'(pwr_n), 0);
    rd_chk(1, 8'h40, "R8 status");
    check("R8 pwr released by read", int'(pwr_n), 1);
    // R10 event coincides with clearing read
    wr(0, 8'h08);
    alarm_evt = 1; bus_rd = 1; bus_addr = 1;
    @(negedge clk);
    alarm_evt = 0; bus_rd = 0;
    check("R10 read returns pre-event", int'(bus_rdata), 8'h00);
    rd_chk(1, 8'hC0, "R10 flag survived");
    // R11 late enable
    wr(0, 8'h00); evt(1); wr(0, 8'h04);
    check("R11 irq_n stays high", int'(irq_n), 1);
    rd_chk(1, 8'h20, "R11 no request");
    // R12 writes to status / unmapped
    wr(0, 8'h5A); wr(1, 8'hFF); wr(3, 8'hFF);
    rd_chk(1, 8'h00, "R12 status unchanged");
    rd_chk(0, 8'h5A, "R12 ctrl unchanged");
    rd_chk(2, 8'h00, "R12 unmapped reads zero");
    // randomised traffic against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      bus_addr = 2'($urandom_range(0, 3));
      bus_wr = (r < 15);
      bus_rd = (r >= 15 && r < 40);
      bus_wdata = 8'($urandom);
      alarm_evt = ($urandom_range(0, 9) == 0);
      kick_evt  = ($urandom_range(0, 9) == 0);
      wdog_evt  = ($urandom_range(0, 9) == 0);
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0; alarm_evt = 0; kick_evt = 0; wdog_evt = 0;
    repeat (PLEN + 2) @(negedge clk);
    finish_run();
  end
endmodule